// File: doc/BRIEF.md
# Byte-Handshake I2C Bus Master

This block is an I2C bus master that software drives one byte at a time through four 8-bit registers: control, status, data and own address. Software loads a byte into the data register and writes the status register to start a transfer. The block then produces the START, clocks the byte out MSB first and samples the acknowledge. At the end of every byte, whether address or data, it raises a pending flag and holds SCL low until software clears that flag.

While the flag is set, software chooses what comes next. It can load another byte, switch to receive, request a repeated START, or request a STOP. In receive mode the block shifts a byte in and places it in the data register. It then acknowledges the byte or not, according to the ACK-generation control bit, so a read is ended by clearing that bit before the last byte. The SCL rate comes from the system clock through a prescale of 16 or 512 followed by a divide by (divisor + 1).

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, SCL and SDA are both released (1), all four registers read 0, the busy flag (status bit 5) is 0 and irq is 0.
- R2: The SCL period is P*(D+1) system clocks. D is control[3:0]. P is 16 when control bit 6 is 0 and 512 when it is 1.
- R3: When idle, a status write (address 1) with bit 7 set (master), bit 5 set (START/STOP) and bit 4 set (enable) issues a START and sends the data register (address 2) MSB first as the address byte. The same write with bit 4 clear is ignored.
- R4: At the end of each byte, control bit 4 (pending) sets and irq equals pending AND control bit 5. SCL stays low while pending is set. Writing control with bit 4 = 0 clears pending. Writing it with bit 4 = 1 when not pending leaves pending at 0.
- R5: Status bit 0 holds the SDA level sampled in the acknowledge slot. After a transmitted byte it is 0 when the target acknowledged and 1 when nobody did.
- R6: A status write with bit 5 clear while busy, followed by clearing pending, produces a STOP. Busy then returns to 0.
- R7: A status write with bit 5 set while busy, followed by clearing pending, produces a repeated START with no STOP in between. It sends the data register as a new address byte. The mode in status bits 7:6 written then applies to the following bytes.
- R8: With mode 2'b10 (receive), each data byte after the address is shifted in MSB first and appears in the data register when pending sets. The master drives ACK (SDA low) in the acknowledge slot if control bit 7 is 1 and NACK if it is 0. Mode 2'b11 transmits the data register.
- R9: The own-address register (address 3) holds the last value written to it.
- R10: Outside START and STOP, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Pending AND interrupt enable |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive: 0 pulls low, 1 releases |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The bench runs a behavioural target at 7-bit address 0x50 on a wired-AND SDA line. Against it, the block performs a plain write, an address that no target answers, and a write-address / repeated-START / two-byte read sequence. These separate the acknowledged and unacknowledged address paths, the transmit and receive data paths, and a master ACK from a master NACK. The START and STOP counts the target records show whether a repeated START was mistaken for a STOP-START pair. SCL periods are measured with the 16 and 512 prescales at two divisor values, and SCL is held low across a long pending window. An ignored START, a write of 1 to pending when nothing is pending, and a transfer with the interrupt disabled are each checked at the ports.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i
);
  localparam int QLO = PRE_LO / 4;
  localparam int QHI = PRE_HI / 4;
  localparam int PW  = $clog2(QHI);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_HOLD, S_RSTART, S_STOP} st_t;
  st_t st;

  logic          ackgen, presel, irq_en, pend;
  logic [3:0]    div;
  logic [1:0]    mode;
  logic          en, nack;
  logic [7:0]    data, own, shreg;
  logic [3:0]    bitc;
  logic [1:0]    ph;
  logic          addr_ph, stop_req, rs_req;
  logic          scl_q, sda_q;
  logic [PW-1:0] pre_cnt;
  logic [3:0]    div_cnt;

  wire busy = (st != S_IDLE);
  wire tx   = addr_ph | mode[0];
  wire [PW-1:0] pre_max = presel ? PW'(QHI - 1) : PW'(QLO - 1);
  wire tick = (pre_cnt == pre_max) && (div_cnt == div);
  wire wr_ctrl = reg_we && reg_addr == 2'd0;
  wire wr_stat = reg_we && reg_addr == 2'd1;

  assign scl_o = scl_q;
  assign sda_o = sda_q;
  assign irq   = pend & irq_en;

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {ackgen, presel, irq_en, pend, div};
      2'd1:    reg_rdata = {mode, busy, en, 3'b000, nack};
      2'd2:    reg_rdata = data;
      default: reg_rdata = own;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (st == S_IDLE || st == S_HOLD) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_cnt == pre_max) begin
      pre_cnt <= '0;
      div_cnt <= (div_cnt == div) ? 4'd0 : div_cnt + 4'd1;
    end else
      pre_cnt <= pre_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      {ackgen, presel, irq_en, pend, div} <= '0;
      {mode, en, nack} <= '0;
      data <= '0; own <= '0; shreg <= '0;
      bitc <= '0; ph <= '0;
      addr_ph <= 1'b0; stop_req <= 1'b0; rs_req <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        {ackgen, presel, irq_en} <= reg_wdata[7:5];
        div <= reg_wdata[3:0];
        if (!reg_wdata[4]) pend <= 1'b0;
      end
      if (wr_stat) begin
        mode <= reg_wdata[7:6];
        en   <= reg_wdata[4];
        if (busy) begin
          rs_req   <= reg_wdata[5];
          stop_req <= !reg_wdata[5];
        end
      end
      if (reg_we && reg_addr == 2'd2) data <= reg_wdata;
      if (reg_we && reg_addr == 2'd3) own  <= reg_wdata;

      case (st)
        S_IDLE: begin
          scl_q <= 1'b1; sda_q <= 1'b1;
          if (wr_stat && reg_wdata[7] && reg_wdata[5] && reg_wdata[4]) begin
            st <= S_START; ph <= 2'd0; shreg <= data; addr_ph <= 1'b1;
          end
        end
        S_START: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd0) sda_q <= 1'b0;
          else begin
            scl_q <= 1'b0; st <= S_BITS; ph <= 2'd0; bitc <= 4'd0;
          end
        end
        S_BITS: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_q <= (bitc == 4'd8) ? (tx | !ackgen) : (!tx | shreg[7]);
            2'd1: scl_q <= 1'b1;
            2'd2: if (bitc == 4'd8) nack <= sda_i;
                  else shreg <= {shreg[6:0], sda_i};
            default: begin
              scl_q <= 1'b0;
              if (bitc == 4'd8) begin
                st <= S_HOLD; pend <= 1'b1;
                if (!tx) data <= shreg;
              end else
                bitc <= bitc + 4'd1;
            end
          endcase
        end
        S_HOLD: if (!pend) begin
          ph <= 2'd0; bitc <= 4'd0;
          if (stop_req) begin
            st <= S_STOP; sda_q <= 1'b0; stop_req <= 1'b0;
          end else if (rs_req) begin
            st <= S_RSTART; sda_q <= 1'b1; rs_req <= 1'b0;
            shreg <= data; addr_ph <= 1'b1;
          end else begin
            st <= S_BITS; shreg <= data; addr_ph <= 1'b0;
          end
        end
        S_RSTART: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: scl_q <= 1'b1;
            2'd1: sda_q <= 1'b0;
            default: begin
              scl_q <= 1'b0; st <= S_BITS; ph <= 2'd0; bitc <= 4'd0;
            end
          endcase
        end
        default: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: scl_q <= 1'b1;
            2'd1: sda_q <= 1'b1;
            default: st <= S_IDLE;
          endcase
        end
      endcase
    end

  // R4
  scl_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !scl_o);

  // R10
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BITS && scl_o && $past(scl_o)) |-> $stable(sda_o));

  // R3
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && !sda_o) |-> scl_o);

  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (scl_o && sda_o));

  // R4
  pend_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (irq == irq_en));
endmodule

// File: tb/test_i2c_byte_master.sv
`timescale 1ns/1ps
module test_i2c_byte_master;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq, scl_o, sda_o;
  logic sl_drive = 0;
  wire sda_bus = sda_o & ~sl_drive;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_bus));

  // behavioural target at address 0x50
  int bc = 0, wr_n = 0, rd_i = 0, starts = 0, stops = 0;
  logic [7:0] sh = 0, txb = 0;
  logic [7:0] wr_log [4];
  bit in_addr = 0, match = 0, rw = 0, stx = 0;
  logic last_mack = 1;

  always @(negedge sda_bus) if (scl_o) begin
    starts++; bc = 0; in_addr = 1; stx = 0; sl_drive = 0;
  end
  always @(posedge sda_bus) if (scl_o) begin
    stops++; stx = 0;
  end
  always @(posedge scl_o) begin
    if (bc < 8) sh = {sh[6:0], sda_bus};
    else if (bc == 8) last_mack = sda_bus;
    bc++;
  end
  always @(negedge scl_o) begin
    if (bc == 8) begin
      if (!stx) begin
        if (in_addr) begin
          match = (sh[7:1] == 7'h50); rw = sh[0]; sl_drive = match;
        end else begin
          if (wr_n < 4) wr_log[wr_n] = sh;
          wr_n++; sl_drive = 1;
        end
      end else sl_drive = 0;
    end else if (bc == 9) begin
      bc = 0;
      if (in_addr) begin in_addr = 0; stx = match & rw; end
      if (stx && !last_mack) begin
        txb = (rd_i == 0) ? 8'h96 : 8'h5A;
        rd_i++; sl_drive = ~txb[7];
      end else begin
        stx = 0; sl_drive = 0;
      end
    end else if (stx && bc >= 1 && bc <= 7) sl_drive = ~txb[7-bc];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_pend(input int tmo, input string req);
    logic [7:0] v;
    for (int i = 0; i < tmo; i++) begin
      rd(2'd0, v);
      if (v[4]) return;
    end
    check(0, req, 0, 1);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd1, v);
      if (!v[5]) return;
    end
    check(0, req, 1, 0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check(scl_o == 1 && sda_o == 1, "R1 lines", {scl_o, sda_o}, 3);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check(v == 0, "R1 reg", v, 0);
    end
    check(irq == 0, "R1 irq", irq, 0);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    int s0 = starts;
    wr(2'd0, 8'hB0);
    rd(2'd0, v);
    check(v[4] == 0 && irq == 0, "R4 pend write 1 ignored", v[4], 0);
    wr(2'd1, 8'hE0);
    repeat (100) @(negedge clk);
    rd(2'd1, v);
    check(v[5] == 0 && scl_o == 1 && starts == s0, "R3 start without enable ignored", v[5], 0);
    wr(2'd3, 8'h7E);
    rd(2'd3, v);
    check(v == 8'h7E, "R9 own address", v, 8'h7E);
  endtask

  task automatic t_write;
    logic [7:0] v;
    bit low;
    int p0;
    wr_n = 0;
    wr(2'd0, 8'hA0);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend(5000, "R4 pend after address");
    rd(2'd1, v);
    check(v[5] == 1, "R3 busy after start", v[5], 1);
    check(v[0] == 0, "R5 address acked", v[0], 0);
    check(irq == 1, "R4 irq", irq, 1);
    low = 1;
    repeat (60) begin @(negedge clk); if (scl_o) low = 0; end
    check(low, "R4 scl held low", scl_o, 0);
    wr(2'd2, 8'h3C);
    wr(2'd0, 8'hA0);
    wait_pend(5000, "R4 pend after data");
    rd(2'd1, v);
    check(v[0] == 0, "R5 data acked", v[0], 0);
    p0 = stops;
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'hA0);
    wait_idle("R6 idle after stop");
    check(stops == p0 + 1, "R6 stop seen", stops, p0 + 1);
    check(wr_n == 1 && wr_log[0] == 8'h3C, "R3 byte received by target", wr_log[0], 8'h3C);
  endtask

  task automatic t_nack;
    logic [7:0] v;
    wr(2'd2, 8'h22);
    wr(2'd1, 8'hF0);
    wait_pend(5000, "R4 pend nack");
    rd(2'd1, v);
    check(v[0] == 1, "R5 unanswered address", v[0], 1);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'hA0);
    wait_idle("R6 idle after nack");
  endtask

  task automatic t_read;
    logic [7:0] v;
    int s0, p0;
    wr_n = 0; rd_i = 0;
    wr(2'd0, 8'hA0);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend(5000, "R4 pend rd addr");
    wr(2'd2, 8'h05);
    wr(2'd0, 8'hA0);
    wait_pend(5000, "R4 pend rd index");
    check(wr_log[0] == 8'h05, "R8 index written", wr_log[0], 8'h05);
    s0 = starts; p0 = stops;
    wr(2'd2, 8'hA1);
    wr(2'd1, 8'hB0);
    wr(2'd0, 8'hA0);
    wait_pend(5000, "R7 pend after restart");
    check(starts == s0 + 1 && stops == p0, "R7 repeated start no stop", stops, p0);
    rd(2'd1, v);
    check(v[0] == 0, "R7 read address acked", v[0], 0);
    wr(2'd0, 8'hA0);
    wait_pend(5000, "R8 pend byte0");
    rd(2'd2, v);
    check(v == 8'h96, "R8 first read byte", v, 8'h96);
    check(last_mack == 0, "R8 master ack", last_mack, 0);
    wr(2'd0, 8'h20);
    wait_pend(5000, "R8 pend byte1");
    rd(2'd2, v);
    check(v == 8'h5A, "R8 second read byte", v, 8'h5A);
    check(last_mack == 1, "R8 master nack", last_mack, 1);
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h20);
    wait_idle("R6 idle after read");
    check(stops == p0 + 1, "R6 stop after read", stops, p0 + 1);
  endtask

  task automatic measure(input logic [7:0] ctl, input int exp, input string req);
    realtime t0, t1;
    wr(2'd0, ctl);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    @(posedge scl_o); t0 = $realtime;
    @(posedge scl_o); t1 = $realtime;
    check(int'((t1 - t0) / 20.0) == exp, req, int'((t1 - t0) / 20.0), exp);
    wait_pend(20000, "R4 pend in rate test");
    if (!ctl[5]) check(irq == 0, "R4 irq masked", irq, 0);
    wr(2'd1, 8'hD0);
    wr(2'd0, ctl);
    wait_idle("R6 idle after rate test");
  endtask

  initial begin
    #(20ns * 200000);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ignored();
    t_write();
    t_nack();
    t_read();
    measure(8'h82, 48, "R2 period pre16 div2");
    measure(8'hE0, 512, "R2 period pre512 div0");
    measure(8'hA0, 16, "R2 period pre16 div0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule